// File: doc/BRIEF.md
# Multi-Domain Power Mode Controller

This block sequences a small wireless device through four operating modes (active, doze, sleep and deep sleep) and drives the enable for each of its six power domains: always-on, application logic, analogue peripherals, RAM, transceiver logic and radio. Software uses a register-style interface. A configuration write sets the analogue, transceiver and memory-retention bits. Two command pulses request doze or power-down, and a flag sent with the power-down request selects deep sleep.

Each mode has its own way out. Doze ends on any interrupt. Sleep ends only on a wake event from the wake timer, a digital I/O pin or the comparator. Deep sleep ends only on the hardware reset pin. Leaving sleep runs a power-up sequence with a fixed settle count: the application domain comes on first and the CPU clock is released once the count runs out. Entering a low-power mode works the other way round, stopping the clock one cycle before any domain is switched off. Software-controlled domains are not restored on wakeup. Digital I/O state is frozen from the start of a power-down until the CPU clock runs again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low and for `SETTLE_CYCLES` clock edges after it rises, the block is in the power-up sequence: `domApp`=1, `domRam`=1, `cpuClkStop`=1, `modeStatus`=2'b10, `domAna`=`domXcvr`=0. At the following edge it enters active mode: `modeStatus`=2'b00, `cpuClkStop`=0.
- R2: In active mode `domApp`=1, `domRam`=1 and `lfOscEn`=1, and `domAna` and `domXcvr` follow the configuration bits. A `cfgWr` pulse loads `cfgAna`, `cfgXcvr` and `cfgMemHold` at the next edge, but only when the block is in active mode. In any other mode the write is ignored.
- R3: `domRadio` is high exactly when `domXcvr` is high and at least one of `bbTx` or `bbRx` is high, in the same cycle.
- R4: A `cmdDoze` pulse in active mode gives `modeStatus`=2'b01 and `cpuClkStop`=1 from the next edge, with all domains unchanged. An `irq` in doze returns the block to active mode at the next edge. An `irq` in active mode has no effect.
- R5: A `cmdPowerDown` pulse in active mode, with no wake source high, starts a single power-down cycle from the next edge. In that cycle `cpuClkStop`=1, every domain keeps its state, and `modeStatus` is 2'b11 if `cmdDeep` was high with the request or 2'b10 if it was not. The domains switch off at the edge after that. If `cmdPowerDown` and `cmdDoze` arrive together, `cmdPowerDown` takes priority.
- R6: If `wakeTimer`, `wakeDio` or `wakeComp` is high when `cmdPowerDown` is sampled, the request is dropped and the block stays in active mode.
- R7: In sleep `domApp`, `domAna`, `domXcvr` and `domRadio` are 0, `lfOscEn`=1, `modeStatus`=2'b10, and `domRam` equals the memory-hold configuration bit as it stood when the power-down request was accepted.
- R8: Sleep is left only when a wake source is high. An `irq` in sleep is ignored.
- R9: A wake source sampled high in sleep powers `domApp` and `domRam` from the next edge, with `cpuClkStop` held for `SETTLE_CYCLES` cycles. The block then returns to active mode.
- R10: After a wakeup from sleep, `domAna` and `domXcvr` stay 0 until software writes the configuration again.
- R11: In deep sleep every switchable domain is off, including `domRam`, and `lfOscEn`=0 with `modeStatus`=2'b11. Wake sources and `irq` are ignored. Only a low `rstN` leaves this mode, and it leads into the R1 sequence.
- R12: `dioHold` is 1 from the power-down cycle until the CPU clock is released, and 0 in active and doze modes.
- R13: `domAlwaysOn` is 1 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Hardware reset pin, active low, asynchronous |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAna | input | 1 | Analogue domain enable bit to write |
| cfgXcvr | input | 1 | Transceiver domain enable bit to write |
| cfgMemHold | input | 1 | Keep RAM powered during sleep |
| cmdDoze | input | 1 | Doze request pulse |
| cmdPowerDown | input | 1 | Power-down request pulse |
| cmdDeep | input | 1 | Selects deep sleep for a power-down request |
| irq | input | 1 | Interrupt request |
| wakeTimer | input | 1 | Wake timer event |
| wakeDio | input | 1 | Digital I/O wake event |
| wakeComp | input | 1 | Comparator wake event |
| bbTx | input | 1 | Baseband transmit active |
| bbRx | input | 1 | Baseband receive active |
| domAlwaysOn | output | 1 | Always-on domain enable |
| domApp | output | 1 | Application logic domain enable |
| domAna | output | 1 | Analogue peripheral domain enable |
| domRam | output | 1 | RAM domain enable |
| domXcvr | output | 1 | Transceiver logic domain enable |
| domRadio | output | 1 | Radio domain enable |
| cpuClkStop | output | 1 | Stop the CPU clock |
| lfOscEn | output | 1 | Low-frequency oscillator enable |
| dioHold | output | 1 | Freeze digital I/O state |
| modeStatus | output | 2 | 00 active, 01 doze, 10 sleep, 11 deep sleep |

## Verification
Apart from `domRadio`, every output comes from registered state, so a command, an interrupt or a wake event shows up one edge after it is sampled. The power-down cycle lasts exactly one edge. The power-up sequence holds the CPU clock stopped for `SETTLE_CYCLES` edges, counted from the edge that samples the wake event or from reset release. `domRadio` is a combinational gate of `domXcvr` with the baseband activity inputs, so it is checked in the same cycle its inputs change. The bench drives inputs at the falling edge and advances one rising edge at a time. It samples at the next falling edge, so every check lands on the cycle counted above. The configuration sweep covers every combination of memory hold, deep flag, wake source and software domain bits.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_DOZE,
    ST_PDOWN,
    ST_SLEEP,
    ST_DEEP,
    ST_PWRUP
  } pmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchEntry;
    logic clearSw;
    logic loadSettle;
    logic countSettle;
  } pmStrobe_t;

  // Per-mode gating view from control to datapath
  typedef struct packed {
    logic appOn;
    logic swOn;
    logic ramRetain;
    logic lfOn;
    logic cfgOpen;
  } pmView_t;

  localparam logic [1:0] MODE_ACTIVE = 2'b00;
  localparam logic [1:0] MODE_DOZE   = 2'b01;
  localparam logic [1:0] MODE_SLEEP  = 2'b10;
  localparam logic [1:0] MODE_DEEP   = 2'b11;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdDoze,
  input  logic       cmdPowerDown,
  input  logic       irq,
  input  logic       wakeAny,
  input  logic       settleDone,
  input  logic       deepHeld,
  output pmStrobe_t  strb,
  output pmView_t    view,
  output logic       cpuClkStop,
  output logic       dioHold,
  output logic [1:0] modeStatus
);

  pmState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWRUP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (cmdPowerDown) begin
          if (!wakeAny) begin
            stateNext       = ST_PDOWN;
            strb.latchEntry = 1'b1;
          end
        end else if (cmdDoze) begin
          stateNext = ST_DOZE;
        end
      end
      ST_DOZE: begin
        if (irq) stateNext = ST_ACTIVE;
      end
      ST_PDOWN: begin
        strb.clearSw = 1'b1;
        stateNext    = deepHeld ? ST_DEEP : ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wakeAny) begin
          stateNext       = ST_PWRUP;
          strb.loadSettle = 1'b1;
        end
      end
      ST_DEEP: stateNext = ST_DEEP;
      ST_PWRUP: begin
        strb.countSettle = 1'b1;
        if (settleDone) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_PWRUP;
    endcase
  end

  always_comb begin
    view       = '0;
    cpuClkStop = 1'b1;
    dioHold    = 1'b1;
    modeStatus = MODE_SLEEP;
    unique case (state)
      ST_ACTIVE: begin
        view       = '{appOn: 1'b1, swOn: 1'b1, ramRetain: 1'b0, lfOn: 1'b1, cfgOpen: 1'b1};
        cpuClkStop = 1'b0;
        dioHold    = 1'b0;
        modeStatus = MODE_ACTIVE;
      end
      ST_DOZE: begin
        view       = '{appOn: 1'b1, swOn: 1'b1, ramRetain: 1'b0, lfOn: 1'b1, cfgOpen: 1'b0};
        dioHold    = 1'b0;
        modeStatus = MODE_DOZE;
      end
      ST_PDOWN: begin
        view       = '{appOn: 1'b1, swOn: 1'b1, ramRetain: 1'b0, lfOn: 1'b1, cfgOpen: 1'b0};
        modeStatus = deepHeld ? MODE_DEEP : MODE_SLEEP;
      end
      ST_SLEEP: begin
        view       = '{appOn: 1'b0, swOn: 1'b0, ramRetain: 1'b1, lfOn: 1'b1, cfgOpen: 1'b0};
        modeStatus = MODE_SLEEP;
      end
      ST_DEEP: begin
        view       = '0;
        modeStatus = MODE_DEEP;
      end
      ST_PWRUP: begin
        view       = '{appOn: 1'b1, swOn: 1'b1, ramRetain: 1'b0, lfOn: 1'b1, cfgOpen: 1'b0};
        modeStatus = MODE_SLEEP;
      end
      default: begin
        view       = '0;
        modeStatus = MODE_SLEEP;
      end
    endcase
  end

endmodule

// File: rtl/pwr_domain_dp.sv
module pwr_domain_dp
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  pmStrobe_t strb,
  input  pmView_t   view,
  input  logic      cfgWr,
  input  logic      cfgAna,
  input  logic      cfgXcvr,
  input  logic      cfgMemHold,
  input  logic      cmdDeep,
  input  logic      bbTx,
  input  logic      bbRx,
  output logic      settleDone,
  output logic      deepHeld,
  output logic      domAlwaysOn,
  output logic      domApp,
  output logic      domAna,
  output logic      domRam,
  output logic      domXcvr,
  output logic      domRadio,
  output logic      lfOscEn
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;
  logic anaBit, xcvrBit, memHoldBit, ramKeep;

  // Settle counter; reset starts a power-up sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              settleCnt <= CNT_LOAD;
    else if (strb.loadSettle)               settleCnt <= CNT_LOAD;
    else if (strb.countSettle && settleCnt != '0) settleCnt <= settleCnt - 1'b1;
  end
  assign settleDone = (settleCnt == '0);

  // Software configuration bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anaBit     <= 1'b0;
      xcvrBit    <= 1'b0;
      memHoldBit <= 1'b0;
    end else if (strb.clearSw) begin
      anaBit  <= 1'b0;
      xcvrBit <= 1'b0;
    end else if (cfgWr && view.cfgOpen) begin
      anaBit     <= cfgAna;
      xcvrBit    <= cfgXcvr;
      memHoldBit <= cfgMemHold;
    end
  end

  // Entry-time capture of retention and depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramKeep  <= 1'b0;
      deepHeld <= 1'b0;
    end else if (strb.latchEntry) begin
      ramKeep  <= memHoldBit;
      deepHeld <= cmdDeep;
    end
  end

  assign domAlwaysOn = 1'b1;
  assign domApp      = view.appOn;
  assign domAna      = view.swOn & anaBit;
  assign domXcvr     = view.swOn & xcvrBit;
  assign domRadio    = domXcvr & (bbTx | bbRx);
  assign domRam      = view.appOn | (view.ramRetain & ramKeep);
  assign lfOscEn     = view.lfOn;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic       cfgAna,
  input  logic       cfgXcvr,
  input  logic       cfgMemHold,
  input  logic       cmdDoze,
  input  logic       cmdPowerDown,
  input  logic       cmdDeep,
  input  logic       irq,
  input  logic       wakeTimer,
  input  logic       wakeDio,
  input  logic       wakeComp,
  input  logic       bbTx,
  input  logic       bbRx,
  output logic       domAlwaysOn,
  output logic       domApp,
  output logic       domAna,
  output logic       domRam,
  output logic       domXcvr,
  output logic       domRadio,
  output logic       cpuClkStop,
  output logic       lfOscEn,
  output logic       dioHold,
  output logic [1:0] modeStatus
);

  pmStrobe_t strb;
  pmView_t   view;
  logic      settleDone, deepHeld;
  logic      wakeAny;

  assign wakeAny = wakeTimer | wakeDio | wakeComp;

  pwr_mode_fsm fsm_i (
    .clk          (clk),
    .rstN         (rstN),
    .cmdDoze      (cmdDoze),
    .cmdPowerDown (cmdPowerDown),
    .irq          (irq),
    .wakeAny      (wakeAny),
    .settleDone   (settleDone),
    .deepHeld     (deepHeld),
    .strb         (strb),
    .view         (view),
    .cpuClkStop   (cpuClkStop),
    .dioHold      (dioHold),
    .modeStatus   (modeStatus)
  );

  pwr_domain_dp #(.SETTLE_CYCLES(SETTLE_CYCLES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .view        (view),
    .cfgWr       (cfgWr),
    .cfgAna      (cfgAna),
    .cfgXcvr     (cfgXcvr),
    .cfgMemHold  (cfgMemHold),
    .cmdDeep     (cmdDeep),
    .bbTx        (bbTx),
    .bbRx        (bbRx),
    .settleDone  (settleDone),
    .deepHeld    (deepHeld),
    .domAlwaysOn (domAlwaysOn),
    .domApp      (domApp),
    .domAna      (domAna),
    .domRam      (domRam),
    .domXcvr     (domXcvr),
    .domRadio    (domRadio),
    .lfOscEn     (lfOscEn)
  );

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic       wakeTimer,
  input logic       wakeDio,
  input logic       wakeComp,
  input logic       domApp,
  input logic       domAna,
  input logic       domRam,
  input logic       domXcvr,
  input logic       domRadio,
  input logic       cpuClkStop,
  input logic       lfOscEn,
  input logic       dioHold,
  input logic [1:0] modeStatus
);

  logic wk;
  assign wk = wakeTimer | wakeDio | wakeComp;

  AST_RADIO_NEEDS_XCVR: assert property (@(posedge clk) disable iff (!rstN)
    domRadio |-> domXcvr); // R3
  AST_CLK_NEEDS_APP: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkStop |-> domApp); // R9
  AST_DOZE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b01 && irq) |=> (modeStatus == 2'b00)); // R4
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b10 && !domApp && !wk) |=> (modeStatus == 2'b10 && !domApp)); // R8
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b10 && !domApp && wk) |=> (domApp && cpuClkStop && domRam)); // R9
  AST_ANA_OFF_ON_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(domApp) |-> (!domAna && !domXcvr)); // R10
  AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b11 && !domApp) |-> (!domRam && !domAna && !domXcvr && !lfOscEn)); // R11
  AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b11 && !domApp) |=> (modeStatus == 2'b11 && !domApp)); // R11
  AST_DIO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !domApp |-> dioHold); // R12
  AST_DIO_FREE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkStop |-> !dioHold); // R12

endmodule

bind pwr_mode_ctrl pwr_mode_chk chk_i (.*);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

  localparam int S = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 0, cfgAna = 0, cfgXcvr = 0, cfgMemHold = 0;
  logic cmdDoze = 0, cmdPowerDown = 0, cmdDeep = 0, irq = 0;
  logic wakeTimer = 0, wakeDio = 0, wakeComp = 0, bbTx = 0, bbRx = 0;
  logic domAlwaysOn, domApp, domAna, domRam, domXcvr, domRadio;
  logic cpuClkStop, lfOscEn, dioHold;
  logic [1:0] modeStatus;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_CYCLES(S)) dut_i (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setWake(input int src, input logic v);
    wakeTimer = (src == 0) ? v : 1'b0;
    wakeDio   = (src == 1) ? v : 1'b0;
    wakeComp  = (src == 2) ? v : 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 reset status", 32'(modeStatus), 32'd2);
    chk("R1 reset app", 32'(domApp), 32'd1);
    chk("R1 reset clkstop", 32'(cpuClkStop), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < S; i++) begin
      chk("R1 settling clkstop", 32'(cpuClkStop), 32'd1);
      step();
    end
    chk("R1 active status", 32'(modeStatus), 32'd0);
    chk("R1 clock released", 32'(cpuClkStop), 32'd0);
    chk("R13 always on", 32'(domAlwaysOn), 32'd1);
  endtask

  task automatic writeCfg(input logic a, input logic x, input logic m);
    cfgWr = 1; cfgAna = a; cfgXcvr = x; cfgMemHold = m;
    step();
    cfgWr = 0;
  endtask

  initial begin
    doReset();
    chk("R2 ana off after reset", 32'(domAna), 32'd0);
    chk("R2 ram on", 32'(domRam), 32'd1);
    chk("R12 dio free", 32'(dioHold), 32'd0);

    // R2 / R3: config and radio gating sweep
    for (int c = 0; c < 4; c++) begin
      writeCfg(c[0], c[1], 1'b0);
      chk("R2 ana bit", 32'(domAna), 32'(c[0]));
      chk("R2 xcvr bit", 32'(domXcvr), 32'(c[1]));
      for (int b = 0; b < 4; b++) begin
        bbTx = b[0]; bbRx = b[1];
        #1;
        chk("R3 radio gate", 32'(domRadio), 32'(c[1] & (b[0] | b[1])));
      end
      bbTx = 0; bbRx = 0;
    end

    // R4: doze entry/exit, write ignored in doze
    writeCfg(1'b1, 1'b0, 1'b0);
    irq = 1; step(); irq = 0;
    chk("R4 irq no effect in active", 32'(modeStatus), 32'd0);
    cmdDoze = 1; step(); cmdDoze = 0;
    chk("R4 doze status", 32'(modeStatus), 32'd1);
    chk("R4 doze clkstop", 32'(cpuClkStop), 32'd1);
    chk("R4 doze app on", 32'(domApp), 32'd1);
    chk("R4 doze ana kept", 32'(domAna), 32'd1);
    chk("R12 dio free in doze", 32'(dioHold), 32'd0);
    writeCfg(1'b0, 1'b1, 1'b0);
    chk("R2 write ignored in doze", 32'(domAna), 32'd1);
    setWake(0, 1'b1); step(); setWake(0, 1'b0);
    chk("R4 wake does not end doze", 32'(modeStatus), 32'd1);
    irq = 1; step(); irq = 0;
    chk("R4 irq exits doze", 32'(modeStatus), 32'd0);
    chk("R4 clock after doze", 32'(cpuClkStop), 32'd0);
    chk("R2 ana still after doze", 32'(domAna), 32'd1);

    // R6: abort per wake source
    for (int s = 0; s < 3; s++) begin
      setWake(s, 1'b1); cmdPowerDown = 1; step(); cmdPowerDown = 0; setWake(s, 1'b0);
      chk("R6 aborted status", 32'(modeStatus), 32'd0);
      chk("R6 aborted clock", 32'(cpuClkStop), 32'd0);
    end

    // Main sweep over mem hold, deep, wake source and config bits
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 3; s++)
          for (int c = 0; c < 4; c++) begin
            doReset();
            writeCfg(c[0], c[1], m[0]);
            cmdPowerDown = 1; cmdDeep = d[0]; cmdDoze = 1;
            step();
            cmdPowerDown = 0; cmdDeep = 0; cmdDoze = 0;
            chk("R5 pd status", 32'(modeStatus), 32'({1'b1, d[0]}));
            chk("R5 pd clkstop", 32'(cpuClkStop), 32'd1);
            chk("R5 pd app kept", 32'(domApp), 32'd1);
            chk("R5 pd ana kept", 32'(domAna), 32'(c[0]));
            chk("R12 pd dio", 32'(dioHold), 32'd1);
            step();
            if (d[0]) begin
              chk("R11 deep status", 32'(modeStatus), 32'd3);
              chk("R11 deep ram", 32'(domRam), 32'd0);
              chk("R11 deep app", 32'(domApp), 32'd0);
              chk("R11 deep lfosc", 32'(lfOscEn), 32'd0);
              chk("R11 deep xcvr", 32'(domXcvr), 32'd0);
              chk("R13 deep always on", 32'(domAlwaysOn), 32'd1);
              irq = 1; setWake(s, 1'b1); step(); step(); irq = 0; setWake(s, 1'b0);
              chk("R11 deep ignores wake", 32'(modeStatus), 32'd3);
              chk("R11 deep app stays off", 32'(domApp), 32'd0);
            end else begin
              chk("R7 sleep status", 32'(modeStatus), 32'd2);
              chk("R7 sleep app", 32'(domApp), 32'd0);
              chk("R7 sleep ana", 32'(domAna), 32'd0);
              chk("R7 sleep xcvr", 32'(domXcvr), 32'd0);
              chk("R7 sleep ram", 32'(domRam), 32'(m[0]));
              chk("R7 sleep lfosc", 32'(lfOscEn), 32'd1);
              chk("R12 sleep dio", 32'(dioHold), 32'd1);
              bbTx = 1; #1;
              chk("R3 radio off in sleep", 32'(domRadio), 32'd0);
              bbTx = 0;
              irq = 1; step(); irq = 0;
              chk("R8 irq ignored", 32'(domApp), 32'd0);
              chk("R8 still sleep", 32'(modeStatus), 32'd2);
              setWake(s, 1'b1); step(); setWake(s, 1'b0);
              chk("R9 app on", 32'(domApp), 32'd1);
              chk("R9 ram on", 32'(domRam), 32'd1);
              chk("R10 ana off", 32'(domAna), 32'd0);
              chk("R10 xcvr off", 32'(domXcvr), 32'd0);
              for (int i = 1; i < S; i++) begin
                chk("R9 clkstop settling", 32'(cpuClkStop), 32'd1);
                step();
              end
              chk("R9 clkstop last", 32'(cpuClkStop), 32'd1);
              step();
              chk("R9 active", 32'(modeStatus), 32'd0);
              chk("R9 clock released", 32'(cpuClkStop), 32'd0);
              chk("R12 dio released", 32'(dioHold), 32'd0);
              chk("R10 ana stays off", 32'(domAna), 32'd0);
              writeCfg(c[0], c[1], 1'b0);
              chk("R10 ana rewritten", 32'(domAna), 32'(c[0]));
              chk("R10 xcvr rewritten", 32'(domXcvr), 32'(c[1]));
            end
          end

    doReset();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule